// File: doc/BRIEF.md
# Duty-Cycle Correction Controller with Sign Decision, Binary Search and Tracking

This block is the digital heart of a closed-loop duty-cycle corrector. An external comparator reports once per evaluation step whether the corrected clock spends more than half its period high. From that one bit the controller produces two things for an external delay-line adjuster. The first is an inversion select, which picks the true or the inverted input clock. The second is a 6-bit code, which sets how far the falling edge is delayed.

After a start pulse, the first step is used only to choose the inversion. The code is still zero at that step, so the adjuster is neutral. The next six steps resolve the code from its top bit down to its bottom bit by successive approximation. Once the bottom bit is settled, a completion flag rises and stays up. From then on, the same code register behaves as a saturating up/down counter fed by the comparator. The loop therefore stays closed and follows slow drift.

Steps are paced internally at one every second clock, counted from the start pulse. The comparator input is ignored on all other cycles. The code is held in flops and keeps its value for as long as no reset or start pulse arrives.

Top module: `dcc_ctrl`

## Requirements
- R1: A synchronous active-high reset drives sign_inv, delay_code, done and track_mode to 0 and leaves the block idle. While idle, no value of cmp_high changes any output until a start pulse arrives.
- R2: An evaluation step takes effect on every second rising edge after the edge that samples start. cmp_high is ignored on the edges in between, and all outputs hold their values across those edges.
- R3: At the first step after start, sign_inv takes the value of cmp_high, where 1 means the duty is above half. At the same step, delay_code is loaded with only its top bit set (value 32).
- R4: At each of the next six steps, the bit under trial is cleared if cmp_high is 1 and kept if it is 0. The trial bit starts at bit 5 and moves down by one each step. The next lower bit is set as the new trial, except after bit 0.
- R5: done and track_mode rise together at the step that decides bit 0, which is the seventh step after start. Both stay at 1 until a reset or a start pulse.
- R6: In tracking mode, each step decrements delay_code when cmp_high is 1 and increments it when cmp_high is 0.
- R7: In tracking mode, delay_code saturates. It stays at 0 when asked to decrement and stays at 63 when asked to increment.
- R8: A start pulse in any phase clears sign_inv, delay_code, done and track_mode on its edge and restarts the sequence at the sign decision. This holds even on an edge that would otherwise have been a step, and start takes priority over that step.
- R9: In a loop where the comparator sees duty offset d (positive means too long high), done comes with sign_inv = (d > 0) and delay_code = min(|d|, 63).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; steps are derived from it by division |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that (re)starts the correction |
| cmp_high | input | 1 | Comparator result: 1 when output duty is above half |
| sign_inv | output | 1 | 1 selects the inverted input clock |
| delay_code | output | 6 | Falling-edge delay code for the adjuster |
| done | output | 1 | Binary search finished; stays high |
| track_mode | output | 1 | Code register is in up/down counter mode |

## Verification
A start pulse and a pacing step can land on the same rising edge. When they do, the restart must win, and the step pacing must begin again from that edge. The bench provokes this by raising start exactly on a step edge, both during the search and during tracking, with cmp_high driven to a value that would have changed the code. It then judges the outcome in two ways: all outputs must be cleared right after that edge, and the next sign decision must take effect two edges later, not one.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SIGN   = 2'd1,
    PH_SEARCH = 2'd2,
    PH_TRACK  = 2'd3
  } dcc_phase_e;
endpackage

// File: rtl/dcc_step_gen.sv
module dcc_step_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic step
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign step = (cnt_q == LAST);

  // R2: a step is never followed directly by another step
  assert_step_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> !step);
endmodule

// File: rtl/dcc_phase_seq.sv
module dcc_phase_seq
  import dcc_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         cmp,
  output dcc_phase_e   phase,
  output logic [W-1:0] trial,
  output logic         sign_q,
  output logic         done_q
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  dcc_phase_e   ph_q;
  logic [W-1:0] trial_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      trial_q <= '0;
      sign_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (clr) begin
      ph_q    <= PH_SIGN;
      trial_q <= '0;
      sign_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (step) begin
      case (ph_q)
        PH_SIGN: begin
          sign_q  <= cmp;
          trial_q <= TOP_BIT;
          ph_q    <= PH_SEARCH;
        end
        PH_SEARCH: begin
          if (trial_q[0]) begin
            ph_q    <= PH_TRACK;
            done_q  <= 1'b1;
            trial_q <= '0;
          end else begin
            trial_q <= trial_q >> 1;
          end
        end
        default: ;
      endcase
    end
  end

  assign phase = ph_q;
  assign trial = trial_q;

  // R5: completion flag is sticky until restart
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr) |=> done_q);
  // R4: the trial pointer is one-hot at most
  assert_trial_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trial_q));
endmodule

// File: rtl/dcc_msar_reg.sv
module dcc_msar_reg
  import dcc_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         cmp,
  input  dcc_phase_e   phase,
  input  logic [W-1:0] trial,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] CMAX    = '1;
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q;
  logic [W-1:0] search_nxt;
  logic [W-1:0] track_nxt;

  always_comb begin
    search_nxt = (cmp ? (code_q & ~trial) : code_q) | (trial >> 1);
    if (cmp) track_nxt = (code_q == '0)   ? code_q : code_q - 1'b1;
    else     track_nxt = (code_q == CMAX) ? code_q : code_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) code_q <= '0;
    else if (step) begin
      case (phase)
        PH_SIGN:   code_q <= TOP_BIT;
        PH_SEARCH: code_q <= search_nxt;
        PH_TRACK:  code_q <= track_nxt;
        default:   code_q <= code_q;
      endcase
    end
  end

  assign code = code_q;

  // R2: code never moves between steps
  assert_hold_offstep_R2: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(code_q));
  // R4: a high comparator result clears the bit under trial
  assert_trial_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SEARCH && step && !clr && cmp) |=> ((code_q & $past(trial)) == '0));
  // R6: tracking moves the code by at most one per step
  assert_track_unit_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TRACK && step && !clr) |=>
      (code_q == $past(code_q) + 1'b1 || code_q == $past(code_q) - 1'b1 || $stable(code_q)));
  // R7: no wrap at the top
  assert_sat_top_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TRACK && step && !clr && !cmp && code_q == CMAX) |=> (code_q == CMAX));
  // R7: no wrap at the bottom
  assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TRACK && step && !clr && cmp && code_q == '0) |=> (code_q == '0));
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int STEP_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmp_high,
  output logic              sign_inv,
  output logic [CODE_W-1:0] delay_code,
  output logic              done,
  output logic              track_mode
);
  logic              step;
  dcc_phase_e        phase;
  logic [CODE_W-1:0] trial;

  dcc_step_gen #(.DIV(STEP_DIV)) u_step (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .step (step)
  );

  dcc_phase_seq #(.W(CODE_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .step   (step),
    .cmp    (cmp_high),
    .phase  (phase),
    .trial  (trial),
    .sign_q (sign_inv),
    .done_q (done)
  );

  dcc_msar_reg #(.W(CODE_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .clr   (start),
    .step  (step),
    .cmp   (cmp_high),
    .phase (phase),
    .trial (trial),
    .code  (delay_code)
  );

  assign track_mode = (phase == PH_TRACK);

  // R1: reset leaves every output cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!sign_inv && delay_code == '0 && !done && !track_mode));
  // R8: start clears everything on its edge
  assert_start_clear_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> (!sign_inv && delay_code == '0 && !done && !track_mode));
  // R5: completion and tracking rise together
  assert_done_track_R5: assert property (@(posedge clk) disable iff (rst)
    (done == track_mode));
endmodule

// File: tb/dcc_ctrl_bench.sv
module dcc_ctrl_bench;
  localparam int W    = 6;
  localparam int CMAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmp_high = 1'b0;
  logic         sign_inv;
  logic [W-1:0] delay_code;
  logic         done;
  logic         track_mode;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int m_ph, m_ptr, m_code;
  bit m_sign, m_done;

  always #10 clk = ~clk;

  dcc_ctrl #(.CODE_W(W), .STEP_DIV(2)) u_dcc_ctrl (
    .clk(clk), .rst(rst), .start(start), .cmp_high(cmp_high),
    .sign_inv(sign_inv), .delay_code(delay_code), .done(done), .track_mode(track_mode)
  );

  function automatic bit plant(int d, bit s, int code);
    int eff;
    eff = s ? -d : d;
    return (eff + code) > 0;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, sign_inv, m_sign);
    chk(req, delay_code, m_code);
    chk(req, done, m_done);
    chk(req, track_mode, m_done);
  endtask

  task automatic model_clear(int ph);
    m_ph = ph; m_ptr = 0; m_code = 0; m_sign = 0; m_done = 0;
  endtask

  function automatic string model_step(bit c);
    string tag;
    case (m_ph)
      1: begin m_sign = c; m_code = 1 << (W - 1); m_ptr = W - 1; m_ph = 2; tag = "R3"; end
      2: begin
        if (c) m_code = m_code & ~(1 << m_ptr);
        if (m_ptr == 0) begin m_ph = 3; m_done = 1; tag = "R5"; end
        else begin m_ptr--; m_code = m_code | (1 << m_ptr); tag = "R4"; end
      end
      3: begin
        if (c) begin if (m_code > 0) m_code--; end
        else if (m_code < CMAX) m_code++;
        tag = ((m_code == 0) || (m_code == CMAX)) ? "R7" : "R6";
      end
      default: tag = "R1";
    endcase
    return tag;
  endfunction

  // begins and ends at a falling edge
  task automatic do_step(bit c, bit junk);
    string tag;
    cmp_high = junk;
    @(posedge clk); @(negedge clk);
    check_all("R2");
    cmp_high = c;
    @(posedge clk); @(negedge clk);
    tag = model_step(c);
    check_all(tag);
  endtask

  task automatic pulse_start();
    start = 1'b1; cmp_high = $urandom_range(0, 1);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    model_clear(1);
    check_all("R8");
  endtask

  // start lands on the edge that would be a step
  task automatic start_on_step();
    cmp_high = $urandom_range(0, 1);
    @(posedge clk); @(negedge clk);
    check_all("R2");
    pulse_start();
  endtask

  task automatic plant_step(int d);
    do_step(plant(d, sign_inv, int'(delay_code)), $urandom_range(0, 1));
  endtask

  initial begin
    int dummy;
    dummy = $urandom(1234);
    model_clear(0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst = 1'b0;
    // idle: comparator has no effect
    for (int i = 0; i < 3; i++) do_step(1'b1, 1'b1);
    do_step(1'b0, 1'b0);

    // all low: sign 0, code 63, then top saturation
    pulse_start();
    for (int i = 0; i < 7; i++) do_step(1'b0, 1'b1);
    chk("R5", done, 1);
    for (int i = 0; i < 3; i++) do_step(1'b0, 1'b1);
    chk("R7", delay_code, CMAX);

    // all high: sign 1, code 0, then bottom saturation, then one increment
    pulse_start();
    for (int i = 0; i < 7; i++) do_step(1'b1, 1'b0);
    chk("R3", sign_inv, 1);
    for (int i = 0; i < 3; i++) do_step(1'b1, 1'b0);
    chk("R7", delay_code, 0);
    do_step(1'b0, 1'b1);
    chk("R6", delay_code, 1);

    // restart colliding with a search step, then with a tracking step
    pulse_start();
    do_step(1'b1, 1'b0);
    do_step(1'b0, 1'b1);
    start_on_step();
    for (int i = 0; i < 8; i++) do_step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    start_on_step();
    do_step(1'b0, 1'b1);
    chk("R8", sign_inv, 0);

    // reset in the middle of tracking
    for (int i = 0; i < 7; i++) do_step(1'b0, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model_clear(0);
    check_all("R1");
    do_step(1'b1, 1'b1);

    // random closed-loop trials
    for (int t = 0; t < 40; t++) begin
      int d;
      d = $urandom_range(0, 160) - 80;
      if (t == 0) d = 0;
      if (t == 1) d = 63;
      if (t == 2) d = -64;
      pulse_start();
      for (int i = 0; i < 7; i++) plant_step(d);
      chk("R9", sign_inv, (d > 0) ? 1 : 0);
      chk("R9", delay_code, (iabs(d) > CMAX) ? CMAX : iabs(d));
      chk("R9", done, 1);
      for (int i = 0; i < 4; i++) plant_step(d);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule